// File: doc/BRIEF.md
# Serial TDM to T1 Transmit Frame Mapper

The block takes one serial backplane stream running at 2.048 Mbit/s, organised as 32 eight-bit timeslots per 125 us frame, and rebuilds it as a 193-bit T1 transmit frame. A T1 frame is one framing S-bit followed by 24 eight-bit channels. A second serial stream runs in step with the data and carries per-channel signaling in the low nibble of each timeslot. The block delivers that nibble, one strobe per channel, for a downstream robbed-bit inserter. The module clock is the backplane bit clock. A frame pulse marks the first bit of timeslot 0. Each backplane frame is stored in full and is played out as a T1 frame during the following frame period, so the latency is exactly one frame.

In the normal layout, a programmable 24-entry table selects the backplane timeslot for each T1 channel. The S-bit comes either from an external framing-pattern generator or, when override is on, from bit 0 of timeslot 31. In the IMA layout, the backplane frame already holds the S-bit in its first bit position, and the channels follow with no timeslot alignment. The first 193 stream bits then map straight through. Transparent mode suppresses all signaling output and leaves the data path unchanged. When transparent mode is combined with IMA, the whole frame passes straight through. The T1 output enable is high for 193 of the 256 bit periods in each frame and is low for the rest.

Top module: `t1_tx_mapper`

## Requirements
- R1: After reset all outputs are 0. The output enable stays low until a full backplane frame has been stored, which means from the first frame pulse until the second.
- R2: Stream bits are numbered 0 to 255 in arrival order from the frame pulse, with each timeslot's bit 7 arriving first. T1 position k (0 = S-bit, then 8 bits per channel) appears on `t1_bit_o` one clock after backplane position k of the following frame. Channel c bit j is taken from stream position 8*ts(c)+j of the previous frame.
- R3: After reset the table maps channels 1 to 15 to timeslots 1 to 15, and channels 16 to 24 to timeslots 17 to 25.
- R4: A table write with `map_ch_i` in 1..24 sets that channel's timeslot from the next clock onward. Writes with channel 0 or with a channel above 24 change nothing.
- R5: In the normal layout, timeslots that no channel uses, and timeslot 31 when override is off, have no effect on the output.
- R6: In the normal layout the S-bit is `s_gen_i` when override is 0, and stream position 255 (bit 0 of timeslot 31) when override is 1.
- R7: In the IMA layout, T1 position k carries stream position k of the previous frame for k = 0..192. The S-bit is therefore position 0, and both override and `s_gen_i` have no effect.
- R8: Outside transparent mode, `sig_valid_o` pulses for one clock with the first bit of each channel. `sig_o` carries {A,B,C,D}, with A in bit 3, from control bits 3,2,1,0 (positions 8*ts+4..8*ts+7). The control timeslot is ts(c) in the normal layout and c in the IMA layout.
- R9: In transparent mode `sig_valid_o` stays 0 and the data mapping is unchanged. When transparent mode is combined with IMA, the frame passes straight through as in R7.
- R10: `t1_oe_o` is high for positions 0..192 and low for positions 193..255 of every output frame. While it is low, `t1_bit_o` is 0.
- R11: The mode inputs are sampled at the frame pulse. A change in the middle of a frame has no effect until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Backplane bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fp_i | input | 1 | Frame pulse, high with bit 0 of timeslot 0 |
| dst_i | input | 1 | Serial backplane data |
| cst_i | input | 1 | Serial control stream carrying signaling nibbles |
| ima_i | input | 1 | Select the IMA layout |
| transp_i | input | 1 | Select transparent mode |
| sync_ovr_i | input | 1 | Take the S-bit from timeslot 31 bit 0 |
| s_gen_i | input | 1 | S-bit from the external framing generator |
| map_we_i | input | 1 | Channel table write strobe |
| map_ch_i | input | 5 | T1 channel to write (1..24) |
| map_ts_i | input | 5 | Backplane timeslot for that channel |
| t1_bit_o | output | 1 | T1 transmit bit |
| t1_oe_o | output | 1 | T1 bit carries frame content |
| sig_valid_o | output | 1 | Signaling strobe at each channel start |
| sig_o | output | 4 | Signaling nibble {A,B,C,D} |

## Verification
Two things can happen in the same clock. A table write and the first channel bit of an output frame can coincide. A frame pulse, which latches the new mode, can also coincide with the read of the S-bit, which depends on that mode. The bench issues table writes on the frame-pulse cycle and changes the layout at the pulse from one frame to the next. It judges every bit of the frame against a model that applies the new mode from position 0 and the new table entry from position 1. A separate frame changes the IMA select halfway through and expects no effect until the next pulse.

// File: rtl/t1m_pkg.sv
package t1m_pkg;
  localparam int SIG_W = 4;
  typedef struct packed {
    logic ima;
    logic transp;
    logic sovr;
  } mode_t;
endpackage

// File: rtl/tdm_bank_buf.sv
// Two frame banks: one fills from the stream while the other is read whole.
module tdm_bank_buf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_bank_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic             wr_bit_i,
  input  logic             rd_bank_i,
  output logic [DEPTH-1:0] rd_vec_o
);
  logic [DEPTH-1:0] bank0_q, bank1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank0_q <= '0;
      bank1_q <= '0;
    end else if (wr_bank_i) begin
      bank1_q[wr_addr_i] <= wr_bit_i;
    end else begin
      bank0_q[wr_addr_i] <= wr_bit_i;
    end
  end

  assign rd_vec_o = rd_bank_i ? bank1_q : bank0_q;
endmodule

// File: rtl/t1_chan_lut.sv
// Channel-to-timeslot table; entries indexed by channel 1..CH_N.
module t1_chan_lut #(
  parameter int CH_N = 24,
  parameter int CH_W = 5,
  parameter int TS_N = 32,
  parameter int TS_W = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [CH_W-1:0]      wr_ch_i,
  input  logic [TS_W-1:0]      wr_ts_i,
  input  logic [CH_W-1:0]      rd_ch_i,
  output logic [TS_W-1:0]      rd_ts_o,
  output logic [CH_N*TS_W-1:0] map_flat_o
);
  logic [TS_W-1:0] map_q [CH_N];

  for (genvar c = 0; c < CH_N; c++) begin : g_ent
    // default skips timeslot 0 and the middle timeslot
    localparam int DEF = (c + 1 < TS_N / 2) ? c + 1 : c + 2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                map_q[c] <= TS_W'(DEF);
      else if (we_i && wr_ch_i == CH_W'(c + 1))   map_q[c] <= wr_ts_i;
    end
    assign map_flat_o[c*TS_W +: TS_W] = map_q[c];
  end

  always_comb begin
    rd_ts_o = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (rd_ch_i == CH_W'(c + 1)) rd_ts_o = map_q[c];
    end
  end
endmodule

// File: rtl/t1_tx_mapper.sv
// TS_N and TS_BITS must be powers of two.
module t1_tx_mapper
  import t1m_pkg::*;
#(
  parameter  int TS_N       = 32,
  parameter  int TS_BITS    = 8,
  parameter  int CH_N       = 24,
  localparam int FRAME_BITS = TS_N * TS_BITS,
  localparam int T1_BITS    = CH_N * TS_BITS + 1,
  localparam int POS_W      = $clog2(FRAME_BITS),
  localparam int TS_W       = $clog2(TS_N),
  localparam int OFS_W      = $clog2(TS_BITS),
  localparam int CH_W       = $clog2(CH_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_i,
  input  logic             dst_i,
  input  logic             cst_i,
  input  logic             ima_i,
  input  logic             transp_i,
  input  logic             sync_ovr_i,
  input  logic             s_gen_i,
  input  logic             map_we_i,
  input  logic [CH_W-1:0]  map_ch_i,
  input  logic [TS_W-1:0]  map_ts_i,
  output logic             t1_bit_o,
  output logic             t1_oe_o,
  output logic             sig_valid_o,
  output logic [SIG_W-1:0] sig_o
);
  logic [POS_W-1:0] pos_q, pos_cur, k1;
  logic             bank_q, bank_cur;
  logic             primed_q, run_q, run_cur;
  mode_t            mode_q, mode_cur;
  logic             transp_q;

  assign pos_cur  = fp_i ? '0 : pos_q + POS_W'(1);
  assign bank_cur = fp_i ? ~bank_q : bank_q;
  assign run_cur  = fp_i ? primed_q : run_q;
  assign mode_cur = fp_i ? '{ima: ima_i, transp: transp_i, sovr: sync_ovr_i} : mode_q;
  assign transp_q = mode_q.transp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      bank_q   <= 1'b0;
      primed_q <= 1'b0;
      run_q    <= 1'b0;
      mode_q   <= '0;
    end else begin
      pos_q  <= pos_cur;
      bank_q <= bank_cur;
      run_q  <= run_cur;
      mode_q <= mode_cur;
      if (fp_i) primed_q <= 1'b1;
    end
  end

  // frame banks
  logic [FRAME_BITS-1:0] dvec, cvec;

  tdm_bank_buf #(.DEPTH(FRAME_BITS), .AW(POS_W)) u_dbuf (
    .clk_i, .rst_ni, .wr_bank_i(bank_cur), .wr_addr_i(pos_cur),
    .wr_bit_i(dst_i), .rd_bank_i(~bank_cur), .rd_vec_o(dvec)
  );

  tdm_bank_buf #(.DEPTH(FRAME_BITS), .AW(POS_W)) u_cbuf (
    .clk_i, .rst_ni, .wr_bank_i(bank_cur), .wr_addr_i(pos_cur),
    .wr_bit_i(cst_i), .rd_bank_i(~bank_cur), .rd_vec_o(cvec)
  );

  // T1 position decode: position 0 is the S-bit
  logic [CH_W-1:0]   ch_num;
  logic [OFS_W-1:0]  ofs;
  logic [TS_W-1:0]   lut_ts, sig_ts;
  logic [POS_W-1:0]  data_addr;
  logic [CH_N*TS_W-1:0] map_flat;

  assign k1     = pos_cur - POS_W'(1);
  assign ofs    = k1[OFS_W-1:0];
  assign ch_num = CH_W'(k1[POS_W-1:OFS_W]) + CH_W'(1);

  t1_chan_lut #(.CH_N(CH_N), .CH_W(CH_W), .TS_N(TS_N), .TS_W(TS_W)) u_lut (
    .clk_i, .rst_ni, .we_i(map_we_i), .wr_ch_i(map_ch_i), .wr_ts_i(map_ts_i),
    .rd_ch_i(ch_num), .rd_ts_o(lut_ts), .map_flat_o(map_flat)
  );

  assign data_addr = mode_cur.ima ? pos_cur : {lut_ts, ofs};
  assign sig_ts    = mode_cur.ima ? TS_W'(ch_num) : lut_ts;

  logic             in_t1, t1_bit, sig_hit;
  logic [SIG_W-1:0] nib;

  assign in_t1 = 32'(pos_cur) < T1_BITS;

  always_comb begin
    if (mode_cur.ima || pos_cur != '0) t1_bit = dvec[data_addr];
    else if (mode_cur.sovr)            t1_bit = dvec[FRAME_BITS-1];
    else                               t1_bit = s_gen_i;
  end

  // low nibble arrives last: A at offset TS_BITS-4
  for (genvar i = 0; i < SIG_W; i++) begin : g_nib
    assign nib[SIG_W-1-i] = cvec[{sig_ts, OFS_W'(TS_BITS - SIG_W + i)}];
  end

  assign sig_hit = run_cur && in_t1 && !mode_cur.transp && pos_cur != '0 && ofs == '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_bit_o    <= 1'b0;
      t1_oe_o     <= 1'b0;
      sig_valid_o <= 1'b0;
      sig_o       <= '0;
    end else begin
      t1_oe_o     <= run_cur && in_t1;
      t1_bit_o    <= run_cur && in_t1 && t1_bit;
      sig_valid_o <= sig_hit;
      if (sig_hit) sig_o <= nib;
    end
  end
endmodule

// File: rtl/t1_tx_mapper_chk.sv
module t1_tx_mapper_chk #(
  parameter int T1_BITS = 193,
  parameter int POS_W   = 8,
  parameter int CH_N    = 24,
  parameter int CH_W    = 5,
  parameter int FLAT_W  = 120
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fp_i,
  input logic              map_we_i,
  input logic [CH_W-1:0]   map_ch_i,
  input logic [POS_W-1:0]  pos_q,
  input logic              run_q,
  input logic              transp_q,
  input logic              t1_oe_o,
  input logic              sig_valid_o,
  input logic [FLAT_W-1:0] map_flat
);
  a_r1_no_oe_before_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !fp_i) |=> !t1_oe_o);

  a_r2_oe_starts_at_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(t1_oe_o) |-> $past(fp_i));

  a_r10_oe_ends_after_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(t1_oe_o) |-> (32'(pos_q) == T1_BITS));

  a_r8_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o |=> !sig_valid_o);

  a_r8_strobe_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_valid_o |-> t1_oe_o);

  a_r9_transp_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (transp_q && !fp_i) |=> !sig_valid_o);

  a_r4_bad_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_we_i && (map_ch_i == '0 || 32'(map_ch_i) > CH_N)) |=> $stable(map_flat));
endmodule

bind t1_tx_mapper t1_tx_mapper_chk #(
  .T1_BITS(T1_BITS), .POS_W(POS_W), .CH_N(CH_N), .CH_W(CH_W), .FLAT_W(CH_N*TS_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_i(fp_i), .map_we_i(map_we_i),
  .map_ch_i(map_ch_i), .pos_q(pos_q), .run_q(run_q), .transp_q(transp_q),
  .t1_oe_o(t1_oe_o), .sig_valid_o(sig_valid_o), .map_flat(map_flat)
);

// File: tb/t1_tx_mapper_bench.sv
`timescale 1ns/1ps
module t1_tx_mapper_bench;
  logic clk = 0, rst_n = 0;
  logic fp = 0, dst = 0, cst = 0, ima = 0, tr = 0, so = 0, sg = 0;
  logic map_we = 0;
  logic [4:0] map_ch = 0, map_ts = 0;
  logic t1_bit, t1_oe, sig_valid;
  logic [3:0] sig;

  always #2 clk = ~clk;

  t1_tx_mapper u_t1_tx_mapper (
    .clk_i(clk), .rst_ni(rst_n), .fp_i(fp), .dst_i(dst), .cst_i(cst),
    .ima_i(ima), .transp_i(tr), .sync_ovr_i(so), .s_gen_i(sg),
    .map_we_i(map_we), .map_ch_i(map_ch), .map_ts_i(map_ts),
    .t1_bit_o(t1_bit), .t1_oe_o(t1_oe), .sig_valid_o(sig_valid), .sig_o(sig)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int map_m [25];
  bit d_prev [256], c_prev [256], d_cur [256], c_cur [256];
  bit obs [193], obs_b [193];
  bit have_prev = 0;

  // vector: {ima, transp, sovr, sgen, seed[7:0]}
  localparam logic [11:0] VEC [6] = '{
    {4'b0001, 8'd3}, {4'b0010, 8'd9}, {4'b1000, 8'd21},
    {4'b1011, 8'd40}, {4'b0101, 8'd55}, {4'b1100, 8'd77}
  };

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit gen(int s, int p);
    int unsigned h;
    h = (s * 7919) ^ (p * 40503) ^ (s * p * 131);
    h = h ^ (h >> 7) ^ (h >> 13);
    return h[0] ^ h[3];
  endfunction

  function automatic bit mapped(int ts);
    for (int c = 1; c <= 24; c++) if (map_m[c] == ts) return 1;
    return 0;
  endfunction

  // one backplane frame in, previous frame checked out
  task automatic run_frame(bit m_ima, bit m_tr, bit m_so, bit m_sg, int seed,
                           bit flip, bit mid, int wch, int wts, string tag);
    int e_oe, e_s, e_s_act, b_err, o_err, s_err;
    e_s = 0; e_s_act = 0; b_err = 0; o_err = 0; s_err = 0;
    for (int p = 0; p < 256; p++) begin
      d_cur[p] = gen(seed, p);
      c_cur[p] = gen(seed + 77, p);
      if (flip && !mapped(p / 8)) d_cur[p] = ~d_cur[p];
    end
    if (wch >= 1 && wch <= 24) map_m[wch] = wts;
    for (int p = 0; p < 256; p++) begin
      bit eb, ev;
      logic [3:0] en;
      int c, j, ts;
      @(negedge clk);
      fp = (p == 0); dst = d_cur[p]; cst = c_cur[p];
      tr = m_tr; so = m_so; sg = m_sg;
      ima = (mid && p >= 100) ? ~m_ima : m_ima;
      map_we = (p == 0) && (wch >= 0); map_ch = 5'(wch); map_ts = 5'(wts);
      @(posedge clk); #1;
      map_we = 0;
      e_oe = (have_prev && p < 193) ? 1 : 0;
      eb = 0; ev = 0; en = 0;
      if (e_oe == 1) begin
        if (p == 0) eb = m_ima ? d_prev[0] : (m_so ? d_prev[255] : m_sg);
        else begin
          c = (p - 1) / 8 + 1; j = (p - 1) % 8;
          eb = m_ima ? d_prev[p] : d_prev[map_m[c] * 8 + j];
          if (!m_tr && j == 0) begin
            ev = 1;
            ts = m_ima ? c : map_m[c];
            en = {c_prev[ts*8+4], c_prev[ts*8+5], c_prev[ts*8+6], c_prev[ts*8+7]};
          end
        end
        obs[p] = t1_bit;
      end
      if (int'(t1_oe) != e_oe) o_err++;
      if (p == 0 && e_oe == 1) begin e_s = eb; e_s_act = t1_bit; end
      else if (t1_bit !== eb) b_err++;
      if (sig_valid !== ev) s_err++;
      else if (ev && sig !== en) s_err++;
    end
    chk(tag, b_err, 0, "channel bit mismatches");
    chk(have_prev ? "R10" : "R1", o_err, 0, "output enable mismatches");
    chk(m_tr ? "R9" : "R8", s_err, 0, "signaling mismatches");
    if (have_prev) chk(m_ima ? "R7" : "R6", e_s_act, e_s, "S-bit");
    d_prev = d_cur; c_prev = c_cur;
    have_prev = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int c = 1; c <= 24; c++) map_m[c] = (c < 16) ? c : c + 1;
    repeat (3) @(negedge clk);
    chk("R1", {t1_bit, t1_oe, sig_valid, sig}, 0, "outputs in reset");
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1", {t1_bit, t1_oe, sig_valid, sig}, 0, "outputs before first pulse");

    // first stored frame: nothing may come out
    run_frame(0, 0, 0, 1, 1, 0, 0, -1, 0, "R1");
    // default table (R3) with plain S-bit
    run_frame(0, 0, 0, 1, 2, 0, 0, -1, 0, "R3");

    for (int v = 0; v < 6; v++) begin
      logic [11:0] w;
      w = VEC[v];
      run_frame(w[11], w[10], w[9], w[8], int'(w[7:0]), 0, 0, -1, 0,
                w[11] ? "R7" : (w[10] ? "R9" : "R2"));
    end

    // R5: unused slots changed, output must repeat
    run_frame(0, 0, 0, 0, 90, 0, 0, -1, 0, "R2");
    run_frame(0, 0, 0, 0, 90, 1, 0, -1, 0, "R5");
    obs_b = obs;
    run_frame(0, 0, 0, 0, 91, 0, 0, -1, 0, "R5");
    begin
      int diff = 0;
      for (int k = 0; k < 193; k++) if (obs[k] != obs_b[k]) diff++;
      chk("R5", diff, 0, "output bits differing after unused-slot change");
    end

    // R4: remap channel 5 to timeslot 31 at the pulse, then bad writes
    run_frame(0, 0, 0, 1, 100, 0, 0, 5, 31, "R4");
    run_frame(0, 0, 0, 1, 101, 0, 0, 0, 7, "R4");
    run_frame(0, 0, 0, 1, 102, 0, 0, 25, 3, "R4");
    run_frame(0, 0, 1, 0, 103, 0, 0, 24, 0, "R4");

    // R11: IMA select flips mid-frame, latched layout must hold
    run_frame(0, 0, 0, 1, 110, 0, 1, -1, 0, "R11");
    run_frame(1, 0, 0, 0, 111, 0, 1, -1, 0, "R11");
    run_frame(0, 0, 0, 0, 112, 0, 0, -1, 0, "R2");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule